// File: doc/BRIEF.md
# Multicycle Decimal Accumulator Processor

This block is a small accumulator machine that works on three-digit decimal words. It has 100 words of storage, and each word holds a binary value from 0 to 999. A control sequencer moves through fixed stages, one clock per stage. Each stage performs one group of register transfers between the program counter, the memory address register, the memory data register, the instruction register and the accumulator. The five registers, the current stage number and a halted flag are visible on debug outputs, so the progress of every instruction can be followed cycle by cycle.

Software loads a program through a preload write port while the `run` input is low. It then raises `run`, and the machine starts fetching from address 0 after reset. The hundreds digit of a word selects the operation and the low two digits give an address. A leading zero with a nonzero address starts a two-word copy. In that copy the first word names the source address and the following word names the destination address. The all-zero word stops the machine until the next reset.

Top module: `dec_acc_cpu`

## Requirements
- R1: After reset, PC, MAR, MDR, IR, the accumulator, the negative flag and `halted` are all 0, and `dbg_stage` is 0. Memory contents are not affected by reset.
- R2: Every instruction fetch starts in stage 0. In stage 0, MAR takes PC and MDR takes the memory word at PC. In stage 1, IR takes MDR and PC advances by one, wrapping from 99 to 0. Stage encoding: 0 = fetch address, 1 = fetch decode, 2 = operand, 3 = execute, 4 to 8 = copy steps, 9 = halted.
- R3: For word 1XX (add), stage 2 loads MAR with XX and MDR with memory[XX], and stage 3 adds MDR to the accumulator. Example: with 151 at address 21, 006 at address 51 and 724 in the accumulator, the stages show MAR=21/MDR=151, then IR=151/PC=22, then MAR=51/MDR=006, then accumulator 730.
- R4: Add and subtract wrap modulo 1000. Word 2XX subtracts memory[XX] from the accumulator. The negative flag is set when that subtraction borrows and is cleared by add and by load.
- R5: Word 5XX loads memory[XX] into the accumulator. Word 3XX places the accumulator in MDR with MAR=XX in stage 2, and writes MDR to memory[MAR] in stage 3.
- R6: Word 6XX always sets PC to XX. Word 7XX sets PC to XX only when the accumulator equals 0. Word 8XX sets PC to XX only when the negative flag is 0. Each of these finishes in stage 2.
- R7: Word 0XX with XX≠0, followed by a word 0YY, copies memory[XX] to memory[YY] in stages 4 to 8. Stage 4 fetches the second word into MDR. Stage 5 keeps its address and advances PC. Stage 6 sets MAR=XX and MDR=memory[XX]. Stage 7 sets MAR=YY. Stage 8 writes the word. Execution then continues at the word after 0YY.
- R8: Word 000 enters stage 9 and raises `halted`. From then on all registers hold until reset.
- R9: While `run` is low, no register changes. Preload writes put `pre_data` into memory[`pre_addr`].
- R10: Words 4XX and 9XX change nothing but PC and IR, and end after stage 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Step enable for the sequencer and registers |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 7 | Preload word address (0 to 99) |
| pre_data | input | 10 | Preload word value (0 to 999) |
| halted | output | 1 | High once a halt word has executed |
| dbg_stage | output | 4 | Current sequencer stage |
| dbg_pc | output | 7 | Program counter |
| dbg_mar | output | 7 | Memory address register |
| dbg_mdr | output | 10 | Memory data register |
| dbg_ir | output | 10 | Instruction register (first word) |
| dbg_acc | output | 10 | Accumulator |
| dbg_neg | output | 1 | Negative flag from the last subtract |

## Verification
The bench compares register snapshots stage by stage against the traced add example. A sequencer that reads memory a cycle late, or that advances PC in the wrong stage, shows the wrong MAR, MDR or PC at some step. The copy is observed by loading the destination word afterwards and by checking MAR in the source and destination stages, which catches swapped operands or a lost second word. Random subtract operand pairs are mixed with equal values, 0 against 999 and 999 against 0. A design with the wrong borrow or modulo handling then lands on a different halt address or accumulator value. A halt that fails to freeze the machine, or a `run` gate that leaks a step, shows up as registers that move during idle cycles.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int MEM_WORDS = 100;
  localparam int ADDR_W    = $clog2(MEM_WORDS);
  localparam int DATA_W    = 10;
  localparam int WORD_MOD  = 1000;
  localparam int OP_SCALE  = 100;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [3:0] {
    ST_FADR = 4'd0,
    ST_FDEC = 4'd1,
    ST_OPND = 4'd2,
    ST_EXEC = 4'd3,
    ST_MFET = 4'd4,
    ST_MKEP = 4'd5,
    ST_MSRC = 4'd6,
    ST_MDST = 4'd7,
    ST_MWR  = 4'd8,
    ST_HALT = 4'd9
  } stage_e;

  localparam logic [3:0] OP_COPY = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_STO  = 4'd3;
  localparam logic [3:0] OP_LDA  = 4'd5;
  localparam logic [3:0] OP_BRA  = 4'd6;
  localparam logic [3:0] OP_BRZ  = 4'd7;
  localparam logic [3:0] OP_BRP  = 4'd8;

  localparam addr_t LAST_ADR = addr_t'(MEM_WORDS - 1);

  function automatic logic [3:0] op_of(word_t w);
    return 4'(w / word_t'(OP_SCALE));
  endfunction

  function automatic addr_t adr_of(word_t w);
    return addr_t'(w % word_t'(OP_SCALE));
  endfunction
endpackage

// File: rtl/dacc_mem.sv
module dacc_mem #(
  parameter int DEPTH = 100,
  parameter int AW    = 7,
  parameter int DW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dacc_alu.sv
module dacc_alu #(
  parameter int DW      = 10,
  parameter int MODULUS = 1000
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          borrow
);
  localparam logic [DW:0] MOD_X = (DW+1)'(MODULUS);

  logic [DW:0] ax, bx, sum, dif;

  always_comb begin
    ax     = {1'b0, a};
    bx     = {1'b0, b};
    sum    = ax + bx;
    dif    = ax - bx;
    borrow = sub && (a < b);
    if (sub) begin
      res = borrow ? DW'(dif + MOD_X) : DW'(dif);
    end else begin
      res = (sum >= MOD_X) ? DW'(sum - MOD_X) : DW'(sum);
    end
  end
endmodule

// File: rtl/dacc_seq.sv
module dacc_seq
  import dacc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  word_t  mdr,
  input  word_t  ir,
  output stage_e stage
);
  stage_e st_q, st_d;
  logic [3:0] op_new, op_cur;
  logic       adr_new_zero;

  always_comb begin
    op_new       = op_of(mdr);
    adr_new_zero = (adr_of(mdr) == '0);
    op_cur       = op_of(ir);
    st_d         = st_q;
    case (st_q)
      ST_FADR: st_d = ST_FDEC;
      ST_FDEC: st_d = (op_new == OP_COPY && !adr_new_zero) ? ST_MFET : ST_OPND;
      ST_OPND: begin
        case (op_cur)
          OP_ADD, OP_SUB, OP_STO, OP_LDA: st_d = ST_EXEC;
          OP_COPY:                        st_d = ST_HALT;
          default:                        st_d = ST_FADR;
        endcase
      end
      ST_EXEC: st_d = ST_FADR;
      ST_MFET: st_d = ST_MKEP;
      ST_MKEP: st_d = ST_MSRC;
      ST_MSRC: st_d = ST_MDST;
      ST_MDST: st_d = ST_MWR;
      ST_MWR:  st_d = ST_FADR;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_FADR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FADR;
    end else if (en) begin
      st_q <= st_d;
    end
  end

  assign stage = st_q;
endmodule

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu
  import dacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic              halted,
  output logic [3:0]        dbg_stage,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_acc,
  output logic              dbg_neg
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  stage_e stage;
  logic   step_en;

  addr_t pc_q, pc_d, mar_q, mar_d, lo_q, lo_d, rd_addr, pc_inc, adr_ir;
  word_t mdr_q, mdr_d, ir_q, ir_d, acc_q, acc_d, rd_data, alu_res;
  logic  neg_q, neg_d, core_we, alu_sub, alu_borrow, mem_we;
  logic [3:0] op_ir;
  addr_t mem_waddr;
  word_t mem_wdata;

  assign step_en = run && (stage != ST_HALT);

  dacc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (step_en),
    .mdr   (mdr_q),
    .ir    (ir_q),
    .stage (stage)
  );

  assign mem_we    = pre_we || (step_en && core_we);
  assign mem_waddr = pre_we ? pre_addr : mar_q;
  assign mem_wdata = pre_we ? pre_data : mdr_q;

  dacc_mem #(
    .DEPTH (MEM_WORDS),
    .AW    (ADDR_W),
    .DW    (DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  dacc_alu #(
    .DW      (DATA_W),
    .MODULUS (WORD_MOD)
  ) u_alu (
    .a      (acc_q),
    .b      (mdr_q),
    .sub    (alu_sub),
    .res    (alu_res),
    .borrow (alu_borrow)
  );

  assign op_ir   = op_of(ir_q);
  assign adr_ir  = adr_of(ir_q);
  assign pc_inc  = (pc_q == LAST_ADR) ? '0 : pc_q + addr_t'(1);
  assign alu_sub = (op_ir == OP_SUB);

  // register-transfer groups, one per stage
  always_comb begin
    pc_d    = pc_q;
    mar_d   = mar_q;
    mdr_d   = mdr_q;
    ir_d    = ir_q;
    lo_d    = lo_q;
    acc_d   = acc_q;
    neg_d   = neg_q;
    rd_addr = pc_q;
    core_we = 1'b0;
    case (stage)
      ST_FADR, ST_MFET: begin
        rd_addr = pc_q;
        mar_d   = pc_q;
        mdr_d   = rd_data;
      end
      ST_FDEC: begin
        ir_d = mdr_q;
        pc_d = pc_inc;
      end
      ST_OPND: begin
        case (op_ir)
          OP_ADD, OP_SUB, OP_LDA: begin
            rd_addr = adr_ir;
            mar_d   = adr_ir;
            mdr_d   = rd_data;
          end
          OP_STO: begin
            mar_d = adr_ir;
            mdr_d = acc_q;
          end
          OP_BRA: pc_d = adr_ir;
          OP_BRZ: if (acc_q == '0) pc_d = adr_ir;
          OP_BRP: if (!neg_q) pc_d = adr_ir;
          default: ;
        endcase
      end
      ST_EXEC: begin
        case (op_ir)
          OP_ADD, OP_SUB: begin
            acc_d = alu_res;
            neg_d = alu_borrow;
          end
          OP_LDA: begin
            acc_d = mdr_q;
            neg_d = 1'b0;
          end
          OP_STO: core_we = 1'b1;
          default: ;
        endcase
      end
      ST_MKEP: begin
        lo_d = adr_of(mdr_q);
        pc_d = pc_inc;
      end
      ST_MSRC: begin
        rd_addr = adr_ir;
        mar_d   = adr_ir;
        mdr_d   = rd_data;
      end
      ST_MDST: mar_d = lo_q;
      ST_MWR:  core_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      lo_q  <= '0;
      acc_q <= '0;
      neg_q <= 1'b0;
    end else if (step_en) begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      ir_q  <= ir_d;
      lo_q  <= lo_d;
      acc_q <= acc_d;
      neg_q <= neg_d;
    end
  end

  assign halted    = (stage == ST_HALT);
  assign dbg_stage = stage;
  assign dbg_pc    = pc_q;
  assign dbg_mar   = mar_q;
  assign dbg_mdr   = mdr_q;
  assign dbg_ir    = ir_q;
  assign dbg_acc   = acc_q;
  assign dbg_neg   = neg_q;
endmodule

// File: rtl/dacc_chk.sv
module dacc_chk
  import dacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              halted,
  input logic [3:0]        stage,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mar,
  input logic [DATA_W-1:0] mdr,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] acc
);
  p_fetch_mar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halted && stage == 4'd0) |=> (mar == $past(pc)));

  p_fetch_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stage == 4'd1) |=>
      (pc == (($past(pc) == LAST_ADR) ? '0 : $past(pc) + addr_t'(1))));

  p_acc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc < DATA_W'(WORD_MOD));

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(mar)
                && $stable(mdr) && $stable(ir)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(acc) && $stable(mar) && $stable(mdr)
              && $stable(ir) && $stable(stage)));

  p_stage_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= 4'd9);
endmodule

bind dec_acc_cpu dacc_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run),
  .halted (halted),
  .stage  (dbg_stage),
  .pc     (dbg_pc),
  .mar    (dbg_mar),
  .mdr    (dbg_mdr),
  .ir     (dbg_ir),
  .acc    (dbg_acc)
);

// File: tb/dec_acc_cpu_tb_top.sv
module dec_acc_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [9:0] pre_data = '0;
  logic       halted, dbg_neg;
  logic [3:0] dbg_stage;
  logic [6:0] dbg_pc, dbg_mar;
  logic [9:0] dbg_mdr, dbg_ir, dbg_acc;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cycles <= cycles + 1;

  dec_acc_cpu dut_i (
    .clk (clk), .rst_n (rst_n), .run (run),
    .pre_we (pre_we), .pre_addr (pre_addr), .pre_data (pre_data),
    .halted (halted), .dbg_stage (dbg_stage), .dbg_pc (dbg_pc),
    .dbg_mar (dbg_mar), .dbg_mdr (dbg_mdr), .dbg_ir (dbg_ir),
    .dbg_acc (dbg_acc), .dbg_neg (dbg_neg)
  );

  function automatic int f_add(int a, int b);
    return (a + b) % 1000;
  endfunction

  function automatic int f_sub(int a, int b);
    return (a >= b) ? a - b : a + 1000 - b;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic poke(int adr, int val);
    @(negedge clk);
    pre_we   = 1'b1;
    pre_addr = 7'(adr);
    pre_data = 10'(val);
    @(negedge clk);
    pre_we   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    run   = 1'b0;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic snap(string req, int pc, int mar, int mdr, int ir, int acc);
    check(req, "pc",  int'(dbg_pc),  pc);
    check(req, "mar", int'(dbg_mar), mar);
    check(req, "mdr", int'(dbg_mdr), mdr);
    check(req, "ir",  int'(dbg_ir),  ir);
    check(req, "acc", int'(dbg_acc), acc);
  endtask

  task automatic run_to_fetch(int pc);
    int guard = 0;
    while (!(dbg_stage == 4'd0 && int'(dbg_pc) == pc) && guard < 500) begin
      step();
      guard++;
    end
  endtask

  task automatic run_to_halt();
    int guard = 0;
    while (!halted && guard < 2000) begin
      step();
      guard++;
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !done) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected under %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    int a, b, d;
    int pairs_a[5] = '{5, 0, 999, 0, 500};
    int pairs_b[5] = '{5, 999, 0, 0, 499};
    void'($urandom(32'd4711));

    do_reset();
    // R1: reset state
    snap("R1", 0, 0, 0, 0, 0);
    check("R1", "neg", int'(dbg_neg), 0);
    check("R1", "halted", int'(halted), 0);
    check("R1", "stage", int'(dbg_stage), 0);

    // directed program
    poke(0, 620);  poke(20, 550); poke(21, 151); poke(22, 60);  poke(23, 52);
    poke(24, 552); poke(25, 151); poke(26, 355); poke(27, 550); poke(28, 555);
    poke(29, 400); poke(30, 0);
    poke(50, 724); poke(51, 6);   poke(60, 333); poke(52, 111);
    snap("R9", 0, 0, 0, 0, 0);   // preload leaves registers alone

    @(negedge clk); run = 1'b1;
    run_to_fetch(21);
    snap("R3", 21, 50, 724, 550, 724);

    // R9: run low holds everything
    run = 1'b0;
    repeat (3) step();
    snap("R9", 21, 50, 724, 550, 724);
    check("R9", "stage", int'(dbg_stage), 0);
    run = 1'b1;

    // R2/R3: add traced stage by stage
    step(); snap("R2", 21, 21, 151, 550, 724);
    step(); snap("R2", 22, 21, 151, 151, 724);
    check("R3", "stage", int'(dbg_stage), 2);
    step(); snap("R3", 22, 51, 6, 151, 724);
    step(); snap("R3", 22, 51, 6, 151, 730);
    check("R3", "stage", int'(dbg_stage), 0);

    // R7: copy 60 -> 52
    step(); step();
    check("R7", "stage", int'(dbg_stage), 4);
    check("R7", "pc", int'(dbg_pc), 23);
    step(); check("R7", "mar", int'(dbg_mar), 23); check("R7", "mdr", int'(dbg_mdr), 52);
    step(); check("R7", "pc", int'(dbg_pc), 24);
    step(); check("R7", "mar", int'(dbg_mar), 60); check("R7", "mdr", int'(dbg_mdr), 333);
    step(); check("R7", "mar", int'(dbg_mar), 52);
    step(); check("R7", "stage", int'(dbg_stage), 0); check("R7", "pc", int'(dbg_pc), 24);
    run_to_fetch(25);
    check("R7", "copied", int'(dbg_acc), 333);
    check("R5", "load", int'(dbg_acc), 333);

    // R5: store then reload; R10: word 400 is idle
    run_to_fetch(29);
    check("R5", "store reload", int'(dbg_acc), f_add(333, 6));
    run_to_fetch(30);
    check("R10", "acc", int'(dbg_acc), 339);
    check("R10", "ir", int'(dbg_ir), 400);
    run_to_halt();
    check("R8", "halted", int'(halted), 1);
    check("R8", "pc", int'(dbg_pc), 31);
    check("R8", "stage", int'(dbg_stage), 9);
    repeat (6) step();
    snap("R8", 31, int'(dbg_mar), int'(dbg_mdr), 0, 339);
    check("R8", "still halted", int'(halted), 1);

    // subtract and branch program with directed corners and random pairs
    for (int i = 0; i < 30; i++) begin
      if (i < 5) begin
        a = pairs_a[i];
        b = pairs_b[i];
      end else begin
        a = int'($urandom % 1000);
        b = int'($urandom % 1000);
      end
      do_reset();
      check("R1", "pc", int'(dbg_pc), 0);
      poke(0, 510); poke(1, 211); poke(2, 312); poke(3, 706); poke(4, 808);
      poke(5, 0);   poke(6, 0);   poke(7, 0);   poke(8, 110); poke(9, 0);
      poke(10, a);  poke(11, b);
      @(negedge clk); run = 1'b1;
      run_to_halt();
      d = f_sub(a, b);
      if (a == b) begin
        check("R6", "brz pc", int'(dbg_pc), 7);
        check("R4", "zero acc", int'(dbg_acc), 0);
        check("R4", "neg", int'(dbg_neg), 0);
      end else if (a > b) begin
        check("R6", "brp pc", int'(dbg_pc), 10);
        check("R4", "add wrap", int'(dbg_acc), f_add(d, a));
        check("R4", "neg", int'(dbg_neg), 0);
      end else begin
        check("R6", "fallthrough pc", int'(dbg_pc), 6);
        check("R4", "sub wrap", int'(dbg_acc), d);
        check("R4", "neg", int'(dbg_neg), 1);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule